// File: doc/BRIEF.md
# Serial Flag Offset Programming Port

This block keeps the almost-empty and almost-full threshold offsets of a four-queue flow-control device in one long serial chain. It also drives those offsets in parallel to the flag comparators that sit next to it. A five-pin serial port is the only way to load the chain or read it back. The pins are a serial clock, an active-low write enable, an active-low read enable, a data input and a data output.

A master reset, sampled on the serial clock, loads one of four preset offset sets. A two-bit select input picks the set. After reset, software can write the whole chain by holding the write enable low for one clock per bit. It can read the chain back by holding the read enable low. Reading does not disturb the stored offsets. Once every bit has been read out, the data output gives zeros.

Top module: `flag_offset_chain`

## Requirements
- R1: While `mrst_n` is low at a rising `sclk` edge, every queue's empty offset and full offset load the preset picked by `preset_sel`: 7 for 0, 31 for 1, 63 for 2 and 127 for 3. The same edge clears `sdo` to 0.
- R2: At each rising edge with `wen_n` low and `ren_n` high, `sdi` enters the top of the chain and the chain moves one place toward bit 0. After a full-length write, the first bit written sits at bit 0 of queue 0's empty offset. The chain order, from the first bit to the last, is: queue 0 empty LSB to MSB, then queue 0 full LSB to MSB, then queue 1, and so on, ending with queue 3's full MSB.
- R3: At each rising edge with `ren_n` low and `wen_n` high, `sdo` shows the next chain bit in the R2 order. After the first such edge, `sdo` shows bit 0.
- R4: Reading leaves `empty_ofs` and `full_ofs` unchanged.
- R5: Once every chain bit has been shifted out, further read edges give `sdo` = 0.
- R6: Any edge with `ren_n` high sets `sdo` to 0 and restarts the next read at bit 0.
- R7: At an edge with both enables high, the offsets are unchanged.
- R8: At an edge with both enables low, nothing happens. The offsets, `sdo` and the read position all stay as they are.
- R9: Queue q's empty offset is `empty_ofs[q*EMPTY_W +: EMPTY_W]` and its full offset is `full_ofs[q*FULL_W +: FULL_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock; every state change happens on its rising edge |
| mrst_n | input | 1 | Master reset, active low, sampled on `sclk` |
| preset_sel | input | 2 | Selects which preset set loads during master reset |
| wen_n | input | 1 | Serial write enable, active low |
| ren_n | input | 1 | Serial read enable, active low |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output, registered |
| empty_ofs | output | NUM_Q*EMPTY_W | Almost-empty offsets, one slice per queue |
| full_ofs | output | NUM_Q*FULL_W | Almost-full offsets, one slice per queue |

## Verification
The assertions assume that the enables, `sdi` and `mrst_n` are stable and defined at each rising `sclk` edge. They also assume that a master reset edge comes before any other activity. The bench drives all inputs on the falling edge and holds master reset low across the first edges, so both assumptions hold. Every read burst starts after an edge with `ren_n` high, which keeps the first-bit property in force. The bench drives the both-enables-low case only in the middle of a read, where the held position is observable at `sdo`.

// File: rtl/foc_pkg.sv
package foc_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_HOLD  = 2'd3
    } op_e;

    // Enables are active low; both low is a held no-operation.
    function automatic op_e decode_op(input logic wen_n, input logic ren_n);
        op_e op;
        case ({wen_n, ren_n})
            2'b01:   op = OP_WRITE;
            2'b10:   op = OP_READ;
            2'b00:   op = OP_HOLD;
            default: op = OP_IDLE;
        endcase
        return op;
    endfunction

    // Preset offset value for each select code.
    function automatic logic [31:0] preset_code(input logic [1:0] sel);
        logic [31:0] v;
        case (sel)
            2'd0:    v = 32'd7;
            2'd1:    v = 32'd31;
            2'd2:    v = 32'd63;
            default: v = 32'd127;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/foc_preset.sv
module foc_preset #(
    parameter int NUM_Q   = 4,
    parameter int EMPTY_W = 13,
    parameter int FULL_W  = 13,
    parameter int SLOT_W  = EMPTY_W + FULL_W,
    parameter int CHAIN_W = NUM_Q * SLOT_W
) (
    input  logic [1:0]         sel,
    output logic [CHAIN_W-1:0] preset_chain
);
    logic [31:0] code;
    assign code = foc_pkg::preset_code(sel);

    for (genvar q = 0; q < NUM_Q; q++) begin : g_slot
        assign preset_chain[q*SLOT_W +: EMPTY_W]          = EMPTY_W'(code);
        assign preset_chain[q*SLOT_W + EMPTY_W +: FULL_W] = FULL_W'(code);
    end
endmodule

// File: rtl/foc_shift_chain.sv
module foc_shift_chain #(
    parameter int CHAIN_W = 104
) (
    input  logic               sclk,
    input  logic               mrst_n,
    input  foc_pkg::op_e       op,
    input  logic               sdi,
    input  logic [CHAIN_W-1:0] preset_chain,
    output logic [CHAIN_W-1:0] chain
);
    typedef struct packed {
        logic [CHAIN_W-1:0] bits;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            st_d.bits = preset_chain;
        end else if (op == foc_pkg::OP_WRITE) begin
            st_d.bits = {sdi, st_q.bits[CHAIN_W-1:1]};
        end
    end

    always_ff @(posedge sclk) begin
        st_q <= st_d;
    end

    assign chain = st_q.bits;
endmodule

// File: rtl/foc_readout.sv
module foc_readout #(
    parameter int CHAIN_W = 104,
    parameter int CNT_W   = $clog2(CHAIN_W + 1)
) (
    input  logic               sclk,
    input  logic               mrst_n,
    input  foc_pkg::op_e       op,
    input  logic [CHAIN_W-1:0] chain,
    output logic               sdo
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_W);

    typedef struct packed {
        logic [CNT_W-1:0] pos;
        logic             bit_out;
    } rd_t;

    rd_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mrst_n) begin
            st_d.pos     = '0;
            st_d.bit_out = 1'b0;
        end else begin
            case (op)
                foc_pkg::OP_READ: begin
                    if (st_q.pos < LAST) begin
                        st_d.bit_out = chain[st_q.pos];
                        st_d.pos     = st_q.pos + 1'b1;
                    end else begin
                        st_d.bit_out = 1'b0;
                    end
                end
                foc_pkg::OP_HOLD: begin
                    st_d = st_q;
                end
                default: begin
                    st_d.pos     = '0;
                    st_d.bit_out = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge sclk) begin
        st_q <= st_d;
    end

    assign sdo = st_q.bit_out;
endmodule

// File: rtl/flag_offset_chain.sv
module flag_offset_chain #(
    parameter int NUM_Q   = 4,
    parameter int EMPTY_W = 13,
    parameter int FULL_W  = 13
) (
    input  logic                     sclk,
    input  logic                     mrst_n,
    input  logic [1:0]               preset_sel,
    input  logic                     wen_n,
    input  logic                     ren_n,
    input  logic                     sdi,
    output logic                     sdo,
    output logic [NUM_Q*EMPTY_W-1:0] empty_ofs,
    output logic [NUM_Q*FULL_W-1:0]  full_ofs
);
    localparam int SLOT_W  = EMPTY_W + FULL_W;
    localparam int CHAIN_W = NUM_Q * SLOT_W;

    foc_pkg::op_e       op;
    logic [CHAIN_W-1:0] preset_chain;
    logic [CHAIN_W-1:0] chain;

    assign op = foc_pkg::decode_op(wen_n, ren_n);

    foc_preset #(
        .NUM_Q  (NUM_Q),
        .EMPTY_W(EMPTY_W),
        .FULL_W (FULL_W)
    ) u_preset (
        .sel         (preset_sel),
        .preset_chain(preset_chain)
    );

    foc_shift_chain #(
        .CHAIN_W(CHAIN_W)
    ) u_chain (
        .sclk        (sclk),
        .mrst_n      (mrst_n),
        .op          (op),
        .sdi         (sdi),
        .preset_chain(preset_chain),
        .chain       (chain)
    );

    foc_readout #(
        .CHAIN_W(CHAIN_W)
    ) u_readout (
        .sclk  (sclk),
        .mrst_n(mrst_n),
        .op    (op),
        .chain (chain),
        .sdo   (sdo)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_out
        assign empty_ofs[q*EMPTY_W +: EMPTY_W] = chain[q*SLOT_W +: EMPTY_W];
        assign full_ofs[q*FULL_W +: FULL_W]    = chain[q*SLOT_W + EMPTY_W +: FULL_W];
    end
endmodule

// File: rtl/foc_checker.sv
module foc_checker #(
    parameter int NUM_Q   = 4,
    parameter int EMPTY_W = 13,
    parameter int FULL_W  = 13
) (
    input logic                     sclk,
    input logic                     mrst_n,
    input logic                     wen_n,
    input logic                     ren_n,
    input logic                     sdi,
    input logic                     sdo,
    input logic [NUM_Q*EMPTY_W-1:0] empty_ofs,
    input logic [NUM_Q*FULL_W-1:0]  full_ofs
);
    localparam int TOP = NUM_Q * FULL_W - 1;

    assert_write_enter_R2: assert property (@(posedge sclk) disable iff (!mrst_n)
        (!wen_n && ren_n) |=> full_ofs[TOP] == $past(sdi));

    assert_write_advance_R2: assert property (@(posedge sclk) disable iff (!mrst_n)
        (!wen_n && ren_n) |=> empty_ofs[0] == $past(empty_ofs[1]));

    assert_read_first_bit_R3: assert property (@(posedge sclk) disable iff (!mrst_n)
        (wen_n && !ren_n && $past(ren_n)) |=> sdo == $past(empty_ofs[0]));

    assert_read_keeps_R4: assert property (@(posedge sclk) disable iff (!mrst_n)
        (wen_n && !ren_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_idle_sdo_zero_R6: assert property (@(posedge sclk) disable iff (!mrst_n)
        ren_n |=> !sdo);

    assert_idle_hold_R7: assert property (@(posedge sclk) disable iff (!mrst_n)
        (wen_n && ren_n) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    assert_both_low_hold_R8: assert property (@(posedge sclk) disable iff (!mrst_n)
        (!wen_n && !ren_n) |=> ($stable(sdo) && $stable(empty_ofs) && $stable(full_ofs)));
endmodule

bind flag_offset_chain foc_checker #(
    .NUM_Q  (NUM_Q),
    .EMPTY_W(EMPTY_W),
    .FULL_W (FULL_W)
) u_foc_checker (
    .sclk     (sclk),
    .mrst_n   (mrst_n),
    .wen_n    (wen_n),
    .ren_n    (ren_n),
    .sdi      (sdi),
    .sdo      (sdo),
    .empty_ofs(empty_ofs),
    .full_ofs (full_ofs)
);

// File: tb/flag_offset_chain_bench.sv
`timescale 1ns/1ps
module flag_offset_chain_bench;
    localparam int NQ = 4;
    localparam int EW = 13;
    localparam int FW = 13;
    localparam int SW = EW + FW;
    localparam int N  = NQ * SW;

    logic           clk = 1'b0;
    logic           mrst_n = 1'b0;
    logic [1:0]     preset_sel = 2'd0;
    logic           wen_n = 1'b1;
    logic           ren_n = 1'b1;
    logic           sdi = 1'b0;
    logic           sdo;
    logic [NQ*EW-1:0] empty_ofs;
    logic [NQ*FW-1:0] full_ofs;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [N-1:0] pat;

    always #2 clk = ~clk;

    flag_offset_chain #(.NUM_Q(NQ), .EMPTY_W(EW), .FULL_W(FW)) u_flag_offset_chain (
        .sclk(clk), .mrst_n(mrst_n), .preset_sel(preset_sel), .wen_n(wen_n),
        .ren_n(ren_n), .sdi(sdi), .sdo(sdo), .empty_ofs(empty_ofs), .full_ofs(full_ofs)
    );

    task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input logic w, input logic r, input logic d);
        @(negedge clk);
        wen_n = w; ren_n = r; sdi = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [NQ*EW-1:0] exp_empty(input logic [N-1:0] p);
        logic [NQ*EW-1:0] v;
        for (int q = 0; q < NQ; q++)
            for (int b = 0; b < EW; b++) v[q*EW+b] = p[q*SW+b];
        return v;
    endfunction

    function automatic logic [NQ*FW-1:0] exp_full(input logic [N-1:0] p);
        logic [NQ*FW-1:0] v;
        for (int q = 0; q < NQ; q++)
            for (int b = 0; b < FW; b++) v[q*FW+b] = p[q*SW+EW+b];
        return v;
    endfunction

    task automatic t_defaults();
        for (int s = 0; s < 4; s++) begin
            logic [31:0] code;
            logic [NQ*EW-1:0] ee;
            logic [NQ*FW-1:0] ef;
            code = (s == 0) ? 32'd7 : (s == 1) ? 32'd31 : (s == 2) ? 32'd63 : 32'd127;
            for (int q = 0; q < NQ; q++) begin
                ee[q*EW +: EW] = EW'(code);
                ef[q*FW +: FW] = FW'(code);
            end
            @(negedge clk);
            mrst_n = 1'b0; preset_sel = 2'(s); wen_n = 1'b1; ren_n = 1'b0;
            @(posedge clk); #1;
            @(negedge clk);
            mrst_n = 1'b1; ren_n = 1'b1;
            check("R1 empty preset", 256'(empty_ofs), 256'(ee));
            check("R1 full preset", 256'(full_ofs), 256'(ef));
            check("R1 sdo cleared", 256'(sdo), 256'(0));
        end
    endtask

    task automatic t_write(input logic [N-1:0] p);
        for (int i = 0; i < N; i++) step(1'b0, 1'b1, p[i]);
        step(1'b1, 1'b1, 1'b0);
        check("R2 R9 empty slices after write", 256'(empty_ofs), 256'(exp_empty(p)));
        check("R2 R9 full slices after write", 256'(full_ofs), 256'(exp_full(p)));
    endtask

    task automatic t_read(input logic [N-1:0] p);
        step(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < N + 4; k++) begin
            step(1'b1, 1'b0, 1'b0);
            if (k < N) check("R3 read bit order", 256'(sdo), 256'(p[k]));
            else       check("R5 zeros after exhaustion", 256'(sdo), 256'(0));
        end
        check("R4 empty kept after read", 256'(empty_ofs), 256'(exp_empty(p)));
        check("R4 full kept after read", 256'(full_ofs), 256'(exp_full(p)));
        step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_restart(input logic [N-1:0] p);
        step(1'b1, 1'b1, 1'b0);
        check("R6 sdo zero when idle", 256'(sdo), 256'(0));
        for (int k = 0; k < 5; k++) step(1'b1, 1'b0, 1'b0);
        check("R3 mid read bit", 256'(sdo), 256'(p[4]));
        step(1'b1, 1'b1, 1'b0);
        check("R6 sdo zero after release", 256'(sdo), 256'(0));
        step(1'b1, 1'b0, 1'b0);
        check("R6 read restarts at bit 0", 256'(sdo), 256'(p[0]));
        step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_both_low(input logic [N-1:0] p);
        step(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, ~p[k]);
            check("R8 sdo held", 256'(sdo), 256'(p[6]));
        end
        check("R8 empty unchanged", 256'(empty_ofs), 256'(exp_empty(p)));
        check("R8 full unchanged", 256'(full_ofs), 256'(exp_full(p)));
        step(1'b1, 1'b0, 1'b0);
        check("R8 read resumes at next bit", 256'(sdo), 256'(p[7]));
        step(1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_idle(input logic [N-1:0] p);
        for (int k = 0; k < 10; k++) step(1'b1, 1'b1, k[0]);
        check("R7 empty unchanged idle", 256'(empty_ofs), 256'(exp_empty(p)));
        check("R7 full unchanged idle", 256'(full_ofs), 256'(exp_full(p)));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        @(negedge clk);
        mrst_n = 1'b1;
        check("R1 reset preset 0 empty", 256'(empty_ofs[EW-1:0]), 256'(7));
        check("R1 reset sdo", 256'(sdo), 256'(0));
        for (int i = 0; i < N; i++) pat[i] = 1'($urandom);
        t_write(pat);
        t_read(pat);
        t_restart(pat);
        t_both_low(pat);
        t_idle(pat);
        for (int i = 0; i < N; i++) pat[i] = (i % 3 == 0);
        t_write(pat);
        t_read(pat);
        t_defaults();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule